// File: doc/BRIEF.md
# LCD Pixel Bus Formatter

This block turns 32-bit memory words from an upstream pixel queue into panel pixels, one per request from the display timing logic. A word holds either two RGB565 pixels or one pixel with 8 bits per colour. Each pixel is placed on a 24-bit output bus to suit a panel that is 8, 16, 18 or 24 bits wide. A per-byte valid mask can blank bytes of each word before they are decoded. A truncation flag lets the low six bits of each 8-bit colour drive an 18-bit panel.

The upstream side is a valid/ready word port. A new word is taken only once every beat of the held word has been requested; the hand-over may fall in the same cycle as the final beat. The downstream side is driven by `pix_req`. One cycle after each request, the block presents registered `pix_data` together with a `pix_valid` strobe. If no word is held at the time of a request, the block sends zero and raises `underflow` instead. The configuration inputs are expected to stay static while a word is held.

Top module: `lcd_pixel_formatter`

## Requirements
- R1: While reset is held low, and right after it is released, `pix_valid`, `underflow` and `pix_data` are zero and `in_ready` is high.
- R2: `in_ready` is high when no word is held, or when a request consumes the final beat of the held word. It is low otherwise. A word is captured at a clock edge where both `in_valid` and `in_ready` are high.
- R3: With word length code 0 (16 bits per pixel), each word gives two pixels, bits 15:0 first and bits 31:16 second. Each pixel is RGB565: red in 15:11, green in 10:5, blue in 4:0.
- R4: Bus width codes are 0 = 8, 1 = 16, 2 = 18 and 3 = 24 bits. For a 16-bit pixel, a 16-bit bus gets the raw pixel on [15:0]. An 18-bit bus gets {red,0,green,blue,0} on [17:0]. A 24-bit bus gets red at 23:19, green at 15:10 and blue at 7:3, with the other bits zero.
- R5: A 16-bit pixel on an 8-bit bus takes two beats on [7:0], the high byte first. A word therefore takes four beats.
- R6: With word length code 3 (32 bits per pixel), a word is a single pixel with red in 23:16, green in 15:8 and blue in 7:0; bits 31:24 are ignored. On a 24-bit bus with truncation clear, the pixel appears unchanged on [23:0].
- R7: With 32 bits per pixel on a 16- or 18-bit bus and truncation clear, [17:0] carries the top six bits of red, green and blue, in that order from the high end.
- R8: With 32 bits per pixel and the truncation flag set, [17:0] carries the low six bits of each colour. The top two bits of each colour have no effect.
- R9: A byte-mask bit i of 0 forces byte i of the word to zero before decoding. Mask 0x7 drops bits 31:24.
- R10: A request made when no word is held gives `pix_data` zero with `pix_valid` and `underflow` high in the following cycle.
- R11: Word length codes 1 and 2, and code 3 with an 8-bit bus, raise `cfg_error`. In that state each request outputs zero and consumes a whole word.
- R12: `pix_valid` is high exactly in the cycle after a request. With no request, both `pix_valid` and `underflow` are low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word_len | input | 2 | Memory pixel size: 0 = 16 bits, 3 = 32 bits |
| cfg_bus_width | input | 2 | Panel bus: 0 = 8, 1 = 16, 2 = 18, 3 = 24 bits |
| cfg_trunc18 | input | 1 | Use the low six bits of each 8-bit colour |
| cfg_byte_mask | input | 4 | Per-byte valid mask applied to each word |
| in_word | input | 32 | Word from the pixel queue |
| in_valid | input | 1 | `in_word` is valid |
| in_ready | output | 1 | Block can take a word this cycle |
| pix_req | input | 1 | Timing logic requests one beat |
| pix_data | output | 24 | Registered panel data |
| pix_valid | output | 1 | `pix_data` answers the previous request |
| underflow | output | 1 | The previous request found no word |
| cfg_error | output | 1 | Unsupported configuration |

## Verification
Every pixel result is registered once, so it is due in the cycle after its request. The bench raises a request at a falling edge, lets one rising edge pass, and reads `pix_data`, `pix_valid` and `underflow` at the next falling edge. `in_ready` and `cfg_error` are combinational and are read shortly after the inputs change, before any rising edge. A captured word takes effect only after the edge that loads it, so the first request is made no earlier than the falling edge after the load. In the back-to-back case, the new word is loaded at the same edge as the last beat of the old one, and its pixel is due one cycle after that.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

   typedef enum logic [1:0] {
      WLEN_16  = 2'd0,
      WLEN_RS1 = 2'd1,
      WLEN_RS2 = 2'd2,
      WLEN_32  = 2'd3
   } wlen_e;

   typedef enum logic [1:0] {
      BUS_8  = 2'd0,
      BUS_16 = 2'd1,
      BUS_18 = 2'd2,
      BUS_24 = 2'd3
   } bus_e;

   localparam int BEAT_W = 2;

endpackage

// File: rtl/lpf_cfg_decode.sv
module lpf_cfg_decode
   import lpf_pkg::*;
(
   input  logic [1:0]        word_len,
   input  logic [1:0]        bus_width,
   output logic              cfg_bad,
   output logic [BEAT_W-1:0] last_beat
);

   wlen_e wl;
   bus_e  bw;

   assign wl = wlen_e'(word_len);
   assign bw = bus_e'(bus_width);

   always_comb begin
      cfg_bad   = 1'b0;
      last_beat = '0;
      case (wl)
         WLEN_16: last_beat = (bw == BUS_8) ? BEAT_W'(3) : BEAT_W'(1);
         WLEN_32: cfg_bad   = (bw == BUS_8);
         default: cfg_bad   = 1'b1;
      endcase
      if (cfg_bad) last_beat = '0;
   end

endmodule

// File: rtl/lpf_word_hold.sv
module lpf_word_hold
   import lpf_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_word,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              pix_req,
   input  logic [BEAT_W-1:0] last_beat,
   output logic [DATA_W-1:0] word_q,
   output logic              have_q,
   output logic [BEAT_W-1:0] beat_q
);

   logic consume;
   logic at_last;
   logic load;

   assign consume  = pix_req & have_q;
   assign at_last  = (beat_q == last_beat);
   assign in_ready = ~have_q | (consume & at_last);
   assign load     = in_valid & in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         have_q <= 1'b0;
         beat_q <= '0;
      end else if (load) begin
         word_q <= in_word;
         have_q <= 1'b1;
         beat_q <= '0;
      end else if (consume && at_last) begin
         have_q <= 1'b0;
         beat_q <= '0;
      end else if (consume) begin
         beat_q <= beat_q + 1'b1;
      end
   end

   // R2: a held word is not replaced while no request drains it
   a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (have_q && !pix_req) |=> (have_q && $stable(word_q)));

   // R2: a handshake always leaves a word held
   a_r2_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> have_q);

   // R5: the beat index never passes the last beat of the word
   a_r5_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
      have_q |-> (beat_q <= last_beat));

endmodule

// File: rtl/lpf_pixel_map.sv
module lpf_pixel_map
   import lpf_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int OUT_W       = 24,
   parameter int EXPAND_MODE = 0
) (
   input  logic [DATA_W-1:0] word,
   input  logic [BEAT_W-1:0] beat,
   input  logic [1:0]        word_len,
   input  logic [1:0]        bus_width,
   input  logic              trunc18,
   input  logic              cfg_bad,
   output logic [OUT_W-1:0]  pixel
);

   localparam int HALF_W = DATA_W / 2;

   bus_e              bw;
   logic              half_sel;
   logic [HALF_W-1:0] half;
   logic [4:0]        r5;
   logic [5:0]        g6;
   logic [4:0]        b5;
   logic [2:0]        r_pad3;
   logic [1:0]        g_pad2;
   logic [2:0]        b_pad3;
   logic              r_pad1;
   logic              b_pad1;
   logic [7:0]        r8;
   logic [7:0]        g8;
   logic [7:0]        b8;

   assign bw       = bus_e'(bus_width);
   assign half_sel = (bw == BUS_8) ? beat[1] : beat[0];
   assign half     = half_sel ? word[DATA_W-1:HALF_W] : word[HALF_W-1:0];
   assign r5       = half[15:11];
   assign g6       = half[10:5];
   assign b5       = half[4:0];
   assign r8       = word[23:16];
   assign g8       = word[15:8];
   assign b8       = word[7:0];

   generate
      if (EXPAND_MODE == 1) begin : g_replicate
         assign r_pad3 = r5[4:2];
         assign g_pad2 = g6[5:4];
         assign b_pad3 = b5[4:2];
         assign r_pad1 = r5[4];
         assign b_pad1 = b5[4];
      end else begin : g_zero_pad
         assign r_pad3 = '0;
         assign g_pad2 = '0;
         assign b_pad3 = '0;
         assign r_pad1 = 1'b0;
         assign b_pad1 = 1'b0;
      end
   endgenerate

   always_comb begin
      pixel = '0;
      if (!cfg_bad) begin
         if (wlen_e'(word_len) == WLEN_16) begin
            case (bw)
               BUS_8:   pixel = {16'b0, (beat[0] ? half[7:0] : half[15:8])};
               BUS_16:  pixel = {8'b0, half};
               BUS_18:  pixel = {6'b0, r5, r_pad1, g6, b5, b_pad1};
               default: pixel = {r5, r_pad3, g6, g_pad2, b5, b_pad3};
            endcase
         end else if (trunc18) begin
            pixel = {6'b0, r8[5:0], g8[5:0], b8[5:0]};
         end else if (bw == BUS_24) begin
            pixel = {r8, g8, b8};
         end else begin
            pixel = {6'b0, r8[7:2], g8[7:2], b8[7:2]};
         end
      end
   end

endmodule

// File: rtl/lcd_pixel_formatter.sv
module lcd_pixel_formatter
   import lpf_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int OUT_W       = 24,
   parameter int EXPAND_MODE = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            cfg_word_len,
   input  logic [1:0]            cfg_bus_width,
   input  logic                  cfg_trunc18,
   input  logic [DATA_W/8-1:0]   cfg_byte_mask,
   input  logic [DATA_W-1:0]     in_word,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic                  pix_req,
   output logic [OUT_W-1:0]      pix_data,
   output logic                  pix_valid,
   output logic                  underflow,
   output logic                  cfg_error
);

   localparam int NBYTES = DATA_W / 8;

   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("lcd_pixel_formatter: DATA_W must be 32");
      end
      if (OUT_W != 24) begin : g_bad_out_w
         $error("lcd_pixel_formatter: OUT_W must be 24");
      end
      if (EXPAND_MODE != 0 && EXPAND_MODE != 1) begin : g_bad_expand
         $error("lcd_pixel_formatter: EXPAND_MODE must be 0 or 1");
      end
   endgenerate

   logic [BEAT_W-1:0] last_beat;
   logic [DATA_W-1:0] word_q;
   logic [DATA_W-1:0] word_masked;
   logic              have_q;
   logic [BEAT_W-1:0] beat_q;
   logic [OUT_W-1:0]  map_px;

   lpf_cfg_decode u_dec (
      .word_len  (cfg_word_len),
      .bus_width (cfg_bus_width),
      .cfg_bad   (cfg_error),
      .last_beat (last_beat)
   );

   lpf_word_hold #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_word   (in_word),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .pix_req   (pix_req),
      .last_beat (last_beat),
      .word_q    (word_q),
      .have_q    (have_q),
      .beat_q    (beat_q)
   );

   generate
      for (genvar i = 0; i < NBYTES; i++) begin : g_mask
         assign word_masked[i*8 +: 8] = cfg_byte_mask[i] ? word_q[i*8 +: 8] : 8'h00;
      end
   endgenerate

   lpf_pixel_map #(
      .DATA_W      (DATA_W),
      .OUT_W       (OUT_W),
      .EXPAND_MODE (EXPAND_MODE)
   ) u_map (
      .word      (word_masked),
      .beat      (beat_q),
      .word_len  (cfg_word_len),
      .bus_width (cfg_bus_width),
      .trunc18   (cfg_trunc18),
      .cfg_bad   (cfg_error),
      .pixel     (map_px)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pix_data  <= '0;
         pix_valid <= 1'b0;
         underflow <= 1'b0;
      end else begin
         pix_valid <= pix_req;
         underflow <= pix_req & ~have_q;
         if (pix_req) pix_data <= have_q ? map_px : '0;
      end
   end

   // R12: every request is answered by a strobe one cycle later
   a_r12_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      pix_req |=> pix_valid);

   // R12: no request, no strobe and no underflow
   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_req |=> (!pix_valid && !underflow));

   // R10: an underflow beat carries zero data and a strobe
   a_r10_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> (pix_data == '0 && pix_valid));

   // R11: an unsupported setting never puts colour on the bus
   a_r11_error_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_req && cfg_error) |=> (pix_data == '0));

endmodule

// File: tb/lcd_pixel_formatter_tb.sv
`timescale 1ns/1ps
module lcd_pixel_formatter_tb;

   typedef struct packed {
      logic [1:0]  wl;
      logic [1:0]  bw;
      logic        tr;
      logic [3:0]  mask;
      logic [31:0] word;
      logic [2:0]  n;
      logic [23:0] e0;
      logic [23:0] e1;
      logic [23:0] e2;
      logic [23:0] e3;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t TBL [NV] = '{
      // R3 R4: 16bpp on 16-bit bus, low half first
      '{2'd0, 2'd1, 1'b0, 4'hF, 32'h07E0F81F, 3'd2, 24'h00F81F, 24'h0007E0, 24'h0, 24'h0},
      // R4: 16bpp on 24-bit bus, zero padded
      '{2'd0, 2'd3, 1'b0, 4'hF, 32'h07E0F81F, 3'd2, 24'hF800F8, 24'h00FC00, 24'h0, 24'h0},
      // R4: 16bpp on 18-bit bus
      '{2'd0, 2'd2, 1'b0, 4'hF, 32'h07E0F81F, 3'd2, 24'h03E03E, 24'h000FC0, 24'h0, 24'h0},
      // R5: 16bpp on 8-bit bus, high byte first
      '{2'd0, 2'd0, 1'b0, 4'hF, 32'h07E0F81F, 3'd4, 24'h0000F8, 24'h00001F, 24'h000007, 24'h0000E0},
      // R9: mask 0x7 clears the top byte
      '{2'd0, 2'd1, 1'b0, 4'h7, 32'h07E0F81F, 3'd2, 24'h00F81F, 24'h0000E0, 24'h0, 24'h0},
      // R6: 32bpp on 24-bit bus
      '{2'd3, 2'd3, 1'b0, 4'h7, 32'hFF123456, 3'd1, 24'h123456, 24'h0, 24'h0, 24'h0},
      // R8: truncation keeps the low six bits
      '{2'd3, 2'd2, 1'b1, 4'h7, 32'h00C3A5FF, 3'd1, 24'h00397F, 24'h0, 24'h0, 24'h0},
      // R7: 18-bit bus without truncation keeps the top six bits
      '{2'd3, 2'd2, 1'b0, 4'h7, 32'h00C3A5FF, 3'd1, 24'h030A7F, 24'h0, 24'h0, 24'h0},
      // R7: 16-bit bus behaves like 18-bit for 32bpp
      '{2'd3, 2'd1, 1'b0, 4'hF, 32'h00C3A5FF, 3'd1, 24'h030A7F, 24'h0, 24'h0, 24'h0},
      // R9 R6: mask 0x5 keeps bytes 0 and 2
      '{2'd3, 2'd3, 1'b0, 4'h5, 32'hFF123456, 3'd1, 24'h120056, 24'h0, 24'h0, 24'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_word_len = 2'd0;
   logic [1:0]  cfg_bus_width = 2'd1;
   logic        cfg_trunc18 = 1'b0;
   logic [3:0]  cfg_byte_mask = 4'hF;
   logic [31:0] in_word = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic        pix_req = 1'b0;
   logic [23:0] pix_data;
   logic        pix_valid;
   logic        underflow;
   logic        cfg_error;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lcd_pixel_formatter u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_word_len  (cfg_word_len),
      .cfg_bus_width (cfg_bus_width),
      .cfg_trunc18   (cfg_trunc18),
      .cfg_byte_mask (cfg_byte_mask),
      .in_word       (in_word),
      .in_valid      (in_valid),
      .in_ready      (in_ready),
      .pix_req       (pix_req),
      .pix_data      (pix_data),
      .pix_valid     (pix_valid),
      .underflow     (underflow),
      .cfg_error     (cfg_error)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      #100000;
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      chk("R1 pix_valid", {31'b0, pix_valid}, 32'd0);
      chk("R1 underflow", {31'b0, underflow}, 32'd0);
      chk("R1 pix_data", {8'b0, pix_data}, 32'd0);
      chk("R1 in_ready", {31'b0, in_ready}, 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 pix_valid after release", {31'b0, pix_valid}, 32'd0);

      // R10: request with nothing held
      pix_req = 1'b1;
      @(negedge clk);
      pix_req = 1'b0;
      chk("R10 underflow", {31'b0, underflow}, 32'd1);
      chk("R10 pix_valid", {31'b0, pix_valid}, 32'd1);
      chk("R10 pix_data", {8'b0, pix_data}, 32'd0);
      @(negedge clk);
      // R12: idle cycle
      chk("R12 pix_valid idle", {31'b0, pix_valid}, 32'd0);
      chk("R12 underflow idle", {31'b0, underflow}, 32'd0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         logic [23:0] exp_b [4];
         exp_b[0] = TBL[v].e0;
         exp_b[1] = TBL[v].e1;
         exp_b[2] = TBL[v].e2;
         exp_b[3] = TBL[v].e3;
         cfg_word_len  = TBL[v].wl;
         cfg_bus_width = TBL[v].bw;
         cfg_trunc18   = TBL[v].tr;
         cfg_byte_mask = TBL[v].mask;
         in_word       = TBL[v].word;
         in_valid      = 1'b1;
         #1;
         chk($sformatf("R11 no error vec%0d", v), {31'b0, cfg_error}, 32'd0);
         @(negedge clk);
         in_valid = 1'b0;
         #1;
         chk($sformatf("R2 busy ready low vec%0d", v), {31'b0, in_ready}, 32'd0);
         for (int b = 0; b < int'(TBL[v].n); b++) begin
            pix_req = 1'b1;
            @(negedge clk);
            chk($sformatf("R3-R9 vec%0d beat%0d data", v, b), {8'b0, pix_data}, {8'b0, exp_b[b]});
            chk($sformatf("R12 vec%0d beat%0d valid", v, b), {31'b0, pix_valid}, 32'd1);
            chk($sformatf("R10 vec%0d beat%0d no underflow", v, b), {31'b0, underflow}, 32'd0);
         end
         pix_req = 1'b0;
         #1;
         chk($sformatf("R2 ready after drain vec%0d", v), {31'b0, in_ready}, 32'd1);
         @(negedge clk);
      end

      // R2: back-to-back hand-over on the last beat
      cfg_word_len  = 2'd3;
      cfg_bus_width = 2'd3;
      cfg_trunc18   = 1'b0;
      cfg_byte_mask = 4'hF;
      in_word  = 32'h00ABCDEF;
      in_valid = 1'b1;
      @(negedge clk);
      in_word = 32'h00112233;
      #1;
      chk("R2 ready low while holding", {31'b0, in_ready}, 32'd0);
      pix_req = 1'b1;
      #1;
      chk("R2 ready on final beat", {31'b0, in_ready}, 32'd1);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2 first word pixel", {8'b0, pix_data}, 32'h00ABCDEF);
      @(negedge clk);
      chk("R2 second word pixel", {8'b0, pix_data}, 32'h00112233);
      chk("R2 no underflow on hand-over", {31'b0, underflow}, 32'd0);
      pix_req = 1'b0;
      @(negedge clk);
      chk("R12 strobe drops", {31'b0, pix_valid}, 32'd0);

      // R11: reserved word length
      cfg_word_len  = 2'd1;
      cfg_bus_width = 2'd1;
      in_word  = 32'hFFFFFFFF;
      in_valid = 1'b1;
      #1;
      chk("R11 error code 1", {31'b0, cfg_error}, 32'd1);
      @(negedge clk);
      in_valid = 1'b0;
      pix_req  = 1'b1;
      @(negedge clk);
      pix_req = 1'b0;
      chk("R11 zero data", {8'b0, pix_data}, 32'd0);
      chk("R11 strobe", {31'b0, pix_valid}, 32'd1);
      chk("R11 not underflow", {31'b0, underflow}, 32'd0);
      #1;
      chk("R11 word consumed in one beat", {31'b0, in_ready}, 32'd1);

      // R11: 32bpp on 8-bit bus
      cfg_word_len  = 2'd3;
      cfg_bus_width = 2'd0;
      #1;
      chk("R11 error 32bpp 8-bit", {31'b0, cfg_error}, 32'd1);
      cfg_bus_width = 2'd2;
      #1;
      chk("R11 clear on 18-bit", {31'b0, cfg_error}, 32'd0);

      // R1: reset mid-stream clears held word and outputs
      in_word  = 32'h00FFFFFF;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 data after re-reset", {8'b0, pix_data}, 32'd0);
      chk("R1 ready after re-reset", {31'b0, in_ready}, 32'd1);
      pix_req = 1'b1;
      @(negedge clk);
      pix_req = 1'b0;
      chk("R10 underflow after re-reset", {31'b0, underflow}, 32'd1);

      finish_run();
   end

endmodule